// File: doc/BRIEF.md
# Burst capture and playback sequencer

This block runs a strictly alternating two-phase cycle around an external sample FIFO. In the capture phase it enables an input converter. For every conversion-complete pulse it stores one word, stopping as soon as the FIFO signals full. In the playback phase it drains the FIFO one word at a time into an output converter's data port, strobing each word, until the FIFO signals empty. It then resets the FIFO and arms a fresh capture.

The conversion-complete input is asynchronous and active low. It is synchronised and edge-detected, so a low pulse of any length yields one stored word. Between two output-converter updates, a pacing counter set by `pace_gap_i` inserts a minimum gap. All control outputs are active low and rest high. The converter's channel and mode selects are tied to zero, since a single input channel is used.

Top module: `cap_play_seq`

## Requirements
- R1: Each falling edge of `cnv_done_ni` seen while capturing and not full produces exactly one `fifo_wr_no` low cycle carrying `sample_i` on `fifo_wdata_o`, whatever the low pulse length.
- R2: `chan_o` is always 2'b00 and `mode_o` is always 0.
- R3: When `fifo_full_ni` is low during capture, `cnv_en_no` goes high on the next cycle and later conversion pulses produce no write.
- R4: The full condition drives `irq_no` low for exactly one cycle, after which playback starts.
- R5: In playback each word costs one `fifo_rd_no` low cycle; the FIFO read data present in the cycle after the strobe is shown on `dac_data_o` one cycle later, with `dac_wr_no` low for that one cycle, in FIFO order.
- R6: While the FIFO is not empty, consecutive `dac_wr_no` low cycles are exactly `pace_gap_i` + 3 clock cycles apart.
- R7: When `fifo_empty_ni` is low at a read decision, no read is issued. The sequencer then holds every control output high for one cycle, drives `fifo_rst_no` low for RST_CYC cycles, holds all high for one cycle, and lowers `cnv_en_no`.
- R8: During reset `cnv_en_no`, `fifo_wr_no`, `fifo_rd_no`, `fifo_rst_no`, `dac_wr_no` and `irq_no` are high and `dac_data_o` is 0.
- R9: `fifo_rd_no` and `fifo_wr_no` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnv_done_ni | input | 1 | Conversion complete, asynchronous, active low |
| sample_i | input | DW | Converter result |
| fifo_full_ni | input | 1 | FIFO full flag, active low |
| fifo_empty_ni | input | 1 | FIFO empty flag, active low |
| fifo_rdata_i | input | DW | FIFO read data |
| pace_gap_i | input | PACE_W | Extra idle cycles between output updates |
| cnv_en_no | output | 1 | Converter enable, active low |
| chan_o | output | 2 | Converter channel select, fixed 0 |
| mode_o | output | 1 | Converter mode select, fixed 0 |
| fifo_wr_no | output | 1 | FIFO write strobe, active low |
| fifo_wdata_o | output | DW | FIFO write data |
| fifo_rd_no | output | 1 | FIFO read strobe, active low |
| fifo_rst_no | output | 1 | FIFO reset, active low |
| dac_data_o | output | DW | Output converter data |
| dac_wr_no | output | 1 | Output converter load strobe, active low |
| irq_no | output | 1 | Buffer-full request, active low |

## Verification
The bench uses DW=8, RST_CYC=3, PACE_W=4 and a pacing gap of 5, with a four-word behavioural FIFO. The shallow FIFO means a full capture-playback-restart loop completes within a few hundred cycles. A reset pulse of three cycles differs from the minimum of two, so an off-by-one in the reset counter is exposed. The gap of 5 gives a distinctive 8-cycle update spacing. Conversion pulses of 1, 2, 3, 7 and 10 cycles exercise the edge detector, and a pulse sent during playback probes the full lockout.

// File: rtl/cap_play_pkg.sv
package cap_play_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FRST, ST_ARM, ST_CAPT, ST_IRQ,
    ST_RD, ST_LAT, ST_DAC, ST_GAP
  } seq_state_e;
endpackage

// File: rtl/cps_edge_sync.sv
module cps_edge_sync #(
  parameter int STAGES = 2  // >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_ni,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din_ni};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

  assert_fall_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/cps_pace_timer.sv
module cps_pace_timer #(
  parameter int PACE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PACE_W-1:0] val_i,
  input  logic              run_i,
  output logic              last_o
);
  logic [PACE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= val_i;
    else if (run_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == PACE_W'(1));

  // gap state is entered only with a nonzero load
  assert_run_live_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q != 0);
endmodule

// File: rtl/cap_play_seq.sv
module cap_play_seq
  import cap_play_pkg::*;
#(
  parameter int DW      = 8,
  parameter int RST_CYC = 2,  // >= 2
  parameter int PACE_W  = 8,
  parameter int SYNC_N  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_done_ni,
  input  logic [DW-1:0]     sample_i,
  input  logic              fifo_full_ni,
  input  logic              fifo_empty_ni,
  input  logic [DW-1:0]     fifo_rdata_i,
  input  logic [PACE_W-1:0] pace_gap_i,
  output logic              cnv_en_no,
  output logic [1:0]        chan_o,
  output logic              mode_o,
  output logic              fifo_wr_no,
  output logic [DW-1:0]     fifo_wdata_o,
  output logic              fifo_rd_no,
  output logic              fifo_rst_no,
  output logic [DW-1:0]     dac_data_o,
  output logic              dac_wr_no,
  output logic              irq_no
);
  localparam int RCW = $clog2(RST_CYC + 1);

  seq_state_e     state_q;
  logic [RCW-1:0] rcnt_q;
  logic           wr_nq;
  logic [DW-1:0]  wdata_q;
  logic [DW-1:0]  dac_q;
  logic           fall;
  logic           pace_last;
  logic           take;

  cps_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_ni (cnv_done_ni),
    .fall_o (fall)
  );

  cps_pace_timer #(.PACE_W(PACE_W)) u_pace (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_DAC),
    .val_i  (pace_gap_i),
    .run_i  (state_q == ST_GAP),
    .last_o (pace_last)
  );

  // full wins over a coincident edge
  assign take = (state_q == ST_CAPT) && fifo_full_ni && fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rcnt_q  <= '0;
      wr_nq   <= 1'b1;
      wdata_q <= '0;
      dac_q   <= '0;
    end else begin
      wr_nq <= ~take;
      if (take) wdata_q <= sample_i;
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_FRST;
          rcnt_q  <= '0;
        end
        ST_FRST: begin
          if (rcnt_q == RCW'(RST_CYC - 1)) state_q <= ST_ARM;
          else                             rcnt_q  <= rcnt_q + 1'b1;
        end
        ST_ARM:  state_q <= ST_CAPT;
        ST_CAPT: if (!fifo_full_ni) state_q <= ST_IRQ;
        ST_IRQ:  state_q <= ST_RD;
        ST_RD:   state_q <= fifo_empty_ni ? ST_LAT : ST_IDLE;
        ST_LAT: begin
          dac_q   <= fifo_rdata_i;
          state_q <= ST_DAC;
        end
        ST_DAC:  state_q <= (pace_gap_i == '0) ? ST_RD : ST_GAP;
        ST_GAP:  if (pace_last) state_q <= ST_RD;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_en_no    = (state_q != ST_CAPT);
  assign fifo_rst_no  = (state_q != ST_FRST);
  assign fifo_rd_no   = !((state_q == ST_RD) && fifo_empty_ni);
  assign dac_wr_no    = (state_q != ST_DAC);
  assign irq_no       = (state_q != ST_IRQ);
  assign fifo_wr_no   = wr_nq;
  assign fifo_wdata_o = wdata_q;
  assign dac_data_o   = dac_q;
  assign chan_o       = 2'b00;
  assign mode_o       = 1'b0;

  assert_wr_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_wr_no |=> fifo_wr_no);
  assert_full_stops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAPT && !fifo_full_ni) |=> cnv_en_no);
  assert_no_wr_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_wr_no |-> $past(fifo_full_ni));
  assert_irq_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |=> irq_no);
  assert_dac_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_wr_no |=> dac_wr_no);
  assert_en_after_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnv_en_no |-> $past(fifo_rst_no));
  assert_no_clash_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fifo_rd_no && !fifo_wr_no));
endmodule

// File: tb/sim_cap_play_seq.sv
`timescale 1ns/1ps
module sim_cap_play_seq;
  localparam int DW = 8, RST_CYC = 3, PACE_W = 4, PACE = 5, NV = 4;
  // {sample, low pulse length}
  localparam logic [11:0] VEC [NV] = '{
    {8'hA5, 4'd1}, {8'h3C, 4'd3}, {8'hFF, 4'd7}, {8'h00, 4'd2}};

  logic clk = 1'b0, rst_ni = 1'b0, cnv_done_ni = 1'b1;
  logic [DW-1:0] sample_i = '0;
  logic fifo_full_ni, fifo_empty_ni;
  logic [DW-1:0] fifo_rdata;
  logic cnv_en_no, mode_o, fifo_wr_no, fifo_rd_no, fifo_rst_no, dac_wr_no, irq_no;
  logic [1:0] chan_o;
  logic [DW-1:0] fifo_wdata_o, dac_data_o;

  always #2 clk = ~clk;

  cap_play_seq #(.DW(DW), .RST_CYC(RST_CYC), .PACE_W(PACE_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cnv_done_ni(cnv_done_ni), .sample_i(sample_i),
    .fifo_full_ni(fifo_full_ni), .fifo_empty_ni(fifo_empty_ni),
    .fifo_rdata_i(fifo_rdata), .pace_gap_i(PACE_W'(PACE)),
    .cnv_en_no(cnv_en_no), .chan_o(chan_o), .mode_o(mode_o),
    .fifo_wr_no(fifo_wr_no), .fifo_wdata_o(fifo_wdata_o), .fifo_rd_no(fifo_rd_no),
    .fifo_rst_no(fifo_rst_no), .dac_data_o(dac_data_o), .dac_wr_no(dac_wr_no),
    .irq_no(irq_no));

  // four-word FIFO model
  logic [DW-1:0] mem [4];
  logic [1:0] wp, rp;
  logic [2:0] fcnt;
  assign fifo_full_ni  = (fcnt != 3'd4);
  assign fifo_empty_ni = (fcnt != 3'd0);
  always @(posedge clk) begin
    if (!fifo_rst_no) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      if (!fifo_wr_no && fcnt < 3'd4) begin mem[wp] <= fifo_wdata_o; wp <= wp + 1'b1; end
      if (!fifo_rd_no && fcnt > 3'd0) begin fifo_rdata <= mem[rp]; rp <= rp + 1'b1; end
      fcnt <= fcnt + 3'((!fifo_wr_no && fcnt < 3'd4) ? 1 : 0)
                   - 3'((!fifo_rd_no && fcnt > 3'd0) ? 1 : 0);
    end
  end

  // monitor, sampled mid-cycle
  int cyc = 0, rst_run = 0, rst_len = 0, rst_end = 0, en_gap = -1;
  int wr_cnt = 0, rd_cnt = 0, irq_cnt = 0, dac_cnt = 0, clash = 0, sel_bad = 0;
  logic en_prev = 1'b1;
  int dac_cyc [8];
  logic [DW-1:0] dac_val [8];
  always @(negedge clk) if (rst_ni) begin
    cyc++;
    if (!fifo_rst_no) rst_run++;
    else if (rst_run > 0) begin rst_len = rst_run; rst_run = 0; rst_end = cyc; end
    if (!cnv_en_no && en_prev) en_gap = cyc - rst_end;
    en_prev = cnv_en_no;
    if (!fifo_wr_no) wr_cnt++;
    if (!fifo_rd_no) rd_cnt++;
    if (!irq_no) irq_cnt++;
    if (!fifo_rd_no && !fifo_wr_no) clash++;
    if (chan_o != 2'b00 || mode_o != 1'b0) sel_bad++;
    if (!dac_wr_no && dac_cnt < 8) begin
      dac_val[dac_cnt] = dac_data_o; dac_cyc[dac_cnt] = cyc; dac_cnt++;
    end
  end

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse(input logic [DW-1:0] s, input int len);
    sample_i = s;
    cnv_done_ni = 1'b0;
    tick(len);
    cnv_done_ni = 1'b1;
    tick(6);
  endtask

  initial begin
    tick(3);
    // R8 reset state
    chk({cnv_en_no, fifo_wr_no, fifo_rd_no, fifo_rst_no, dac_wr_no, irq_no} == 6'h3F,
        "R8 controls high", {cnv_en_no, fifo_wr_no, fifo_rd_no, fifo_rst_no, dac_wr_no, irq_no}, 63);
    chk(dac_data_o == 0, "R8 dac data", dac_data_o, 0);
    rst_ni = 1'b1;
    while (cnv_en_no) tick(1);
    chk(rst_len == RST_CYC, "R7 fifo reset width", rst_len, RST_CYC);
    chk(en_gap == 1, "R7 enable after reset release", en_gap, 1);

    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][11:4], int'(VEC[i][3:0]));
      chk(wr_cnt == i + 1, "R1 one write per pulse", wr_cnt, i + 1);
      chk(mem[i] == VEC[i][11:4], "R1 written sample", mem[i], VEC[i][11:4]);
    end
    chk(cnv_en_no == 1'b1, "R3 converter off when full", cnv_en_no, 1);
    chk(irq_cnt == 1, "R4 one request cycle", irq_cnt, 1);
    pulse(8'h5A, 1);
    chk(wr_cnt == NV, "R3 pulse ignored after full", wr_cnt, NV);

    while (dac_cnt < NV || cnv_en_no) tick(1);
    for (int i = 0; i < NV; i++)
      chk(dac_val[i] == VEC[i][11:4], "R5 dac word order", dac_val[i], VEC[i][11:4]);
    for (int i = 0; i < NV - 1; i++)
      chk(dac_cyc[i+1] - dac_cyc[i] == PACE + 3, "R6 dac spacing",
          dac_cyc[i+1] - dac_cyc[i], PACE + 3);
    chk(rd_cnt == NV, "R7 no read when empty", rd_cnt, NV);
    chk(rst_len == RST_CYC && en_gap == 1, "R7 restart sequence", rst_len, RST_CYC);

    pulse(8'h81, 10);
    chk(wr_cnt == NV + 1, "R1 long pulse single write", wr_cnt, NV + 1);
    chk(mem[0] == 8'h81, "R1 restart sample", mem[0], 8'h81);
    chk(sel_bad == 0, "R2 selects at zero", sel_bad, 0);
    chk(clash == 0, "R9 no read/write overlap", clash, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R7 watchdog actual=%0d expected<%0d", 20000, 20000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule